// File: doc/BRIEF.md
# Two-Channel Serial ADC Frame Controller

This block is the host side of a link to an 8-bit serial analog-to-digital converter that has a two-input multiplexer and a separate command pin. For each accepted request it runs one framed transaction. It pulls chip select low and generates the serial clock. On the command line it sends a start bit, a mode bit (single-ended or differential) and a select bit (channel, or polarity in differential mode). After the converter's sampling, conversion and null-bit latency, it collects the eight result bits that come back on the data line. The byte is presented with a one-cycle valid strobe, together with the mode and select values that produced it.

The serial clock is derived from the system clock. Each serial period is `2*HALF` system cycles: the clock is low for the first half and high for the second. A frame always contains exactly 16 serial periods. A request that arrives while a frame is still open is dropped. It does not disturb the frame.

The control is one state machine with four states:
- `ST_IDLE`: chip select high, clock low.
- `ST_LOW`: low half of a serial period.
- `ST_HIGH`: high half of a serial period.
- `ST_DONE`: one cycle in which the result is presented.

The transitions are:
- accept: `ST_IDLE` to `ST_LOW`, on a request.
- rise: `ST_LOW` to `ST_HIGH`, at the end of a half period.
- fall: `ST_HIGH` to `ST_LOW`, at the end of a half period that is not the last of the frame.
- close: `ST_HIGH` to `ST_DONE`, after serial period 15.
- release: `ST_DONE` to `ST_IDLE`, always.

Top module: `mux_adc_ctrl`

## Requirements
- R1: After reset, and whenever no frame is open, `adc_cs_n`=1, `adc_sclk`=0, `adc_cmd`=0 and `busy`=0. Also after reset, `res_valid`=0, `res_data`=0, `res_diff`=0 and `res_sel`=0.
- R2: When `req_valid`=1 in an idle cycle, the request is accepted. From the next cycle, `adc_cs_n` stays 0 and `busy` stays 1 for 32*HALF cycles. In cycle t of that window (t = 0 is the first), `adc_sclk` = 1 exactly when (t/HALF) is odd. This gives exactly 16 rising serial edges per frame.
- R3: The command value in serial period p (p = 0 first) is as follows:
  - period 0: 1 (the start bit);
  - period 1: the mode bit, where 1 means differential and 0 means single-ended;
  - period 2: the select bit, where 1 means channel 1 (single-ended) or channel 1 as the positive input (differential);
  - periods 3 to 15: 0.
- R4: `adc_cmd` changes only in a cycle where `adc_sclk` is 0, and it never changes while `adc_sclk` stays high.
- R5: The data line is sampled in the first high cycle of serial periods 8 to 15. Period 8 gives the most significant bit and period 15 the least significant bit. The null bit in period 7 is not used.
- R6: `res_valid` is 1 for exactly one cycle: 32*HALF cycles after the accept cycle, with `adc_cs_n` already 1 and `busy` still 1. In that cycle `res_data` holds the byte. From the accept onward, `res_diff` and `res_sel` show the accepted mode and select bits. They keep these values until the next accept.
- R7: `req_valid` is ignored while a frame is open. The timing, command bits and reported configuration of the open frame are unchanged.
- R8: A request in the `res_valid` cycle is ignored, so `busy` is 0 in the cycle that follows. A request held high is accepted in the first idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Conversion request |
| req_diff | input | 1 | Mode: 1 differential, 0 single-ended |
| req_sel | input | 1 | Channel or polarity select |
| busy | output | 1 | A frame is open or being closed |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | RES_W | Result byte, most significant bit first on the line |
| res_diff | output | 1 | Mode bit used for the current/last result |
| res_sel | output | 1 | Select bit used for the current/last result |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_cmd | output | 1 | Command line to the converter |
| adc_dout | input | 1 | Data line from the converter |

## Verification
The bench keeps a counter t of system cycles since the accept edge. From it, it predicts each output for every cycle:
- chip select and clock in cycle t;
- the command bit of serial period t/(2*HALF);
- the strobe and byte at exactly t = 32*HALF.

The comparison is made on the falling system clock edge. This is half a cycle after the registers settle. A behavioural converter model in the bench reads the command bits on the rising serial edges. It drives the null bit and the result bits on the falling serial edges. As a result, the byte reaches the controller only through the serial timing. The bench also places requests deliberately mid-frame and in the strobe cycle, to check that they are ignored.

// File: rtl/mux_adc_pkg.sv
package mux_adc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_DONE
    } frame_state_t;

    typedef struct packed {
        logic diff;
        logic sel;
    } conv_cfg_t;

endpackage

// File: rtl/mux_adc_phase_timer.sv
module mux_adc_phase_timer #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic first,
    output logic last
);
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CNT_W-1:0] cnt;

    assign first = run && (cnt == '0);
    assign last  = run && (cnt == CNT_W'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || last)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mux_adc_cmd_encoder.sv
module mux_adc_cmd_encoder
    import mux_adc_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0] idx,
    input  conv_cfg_t        cfg,
    output logic             bit_out
);
    always_comb begin
        unique case (idx)
            IDX_W'(0): bit_out = 1'b1;
            IDX_W'(1): bit_out = cfg.diff;
            IDX_W'(2): bit_out = cfg.sel;
            default:   bit_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/mux_adc_result_shifter.sv
module mux_adc_result_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift,
    input  logic         finish,
    input  logic         din,
    output logic [W-1:0] q
);
    logic [W-1:0] sh;
    logic [W-1:0] sh_next;

    assign sh_next = {sh[W-2:0], din};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0;
            q  <= '0;
        end else if (shift) begin
            sh <= sh_next;
            if (finish)
                q <= sh_next;
        end
    end
endmodule

// File: rtl/mux_adc_ctrl.sv
module mux_adc_ctrl
    import mux_adc_pkg::*;
#(
    parameter int HALF       = 4,
    parameter int FRAME_BITS = 16,
    parameter int RES_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_diff,
    input  logic             req_sel,
    output logic             busy,
    output logic             res_valid,
    output logic [RES_W-1:0] res_data,
    output logic             res_diff,
    output logic             res_sel,
    output logic             adc_cs_n,
    output logic             adc_sclk,
    output logic             adc_cmd,
    input  logic             adc_dout
);
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int DATA_FIRST = FRAME_BITS - RES_W;

    frame_state_t     state, state_nx;
    logic [IDX_W-1:0] idx;
    conv_cfg_t        cfg_q;
    logic             ph_first, ph_last, run, cmd_bit;
    logic             last_bit, do_shift;

    assign run      = (state == ST_LOW) || (state == ST_HIGH);
    assign last_bit = (idx == IDX_W'(FRAME_BITS - 1));
    assign do_shift = (state == ST_HIGH) && ph_first && (idx >= IDX_W'(DATA_FIRST));

    mux_adc_phase_timer #(.HALF(HALF)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .first(ph_first), .last(ph_last)
    );

    mux_adc_cmd_encoder #(.IDX_W(IDX_W)) u_enc (
        .idx(idx), .cfg(cfg_q), .bit_out(cmd_bit)
    );

    mux_adc_result_shifter #(.W(RES_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift(do_shift), .finish(last_bit),
        .din(adc_dout), .q(res_data)
    );

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = ST_LOW;
            ST_LOW:  if (ph_last)   state_nx = ST_HIGH;
            ST_HIGH: if (ph_last)   state_nx = last_bit ? ST_DONE : ST_LOW;
            ST_DONE: state_nx = ST_IDLE;
        endcase
    end

    // state register with bit index and latched configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
            cfg_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && req_valid) begin
                idx   <= '0;
                cfg_q <= '{diff: req_diff, sel: req_sel};
            end else if (state == ST_HIGH && ph_last && !last_bit) begin
                idx <= idx + 1'b1;
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        adc_cs_n  = 1'b1;
        adc_sclk  = 1'b0;
        adc_cmd   = 1'b0;
        busy      = 1'b0;
        res_valid = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_LOW:  begin adc_cs_n = 1'b0; adc_cmd = cmd_bit; busy = 1'b1; end
            ST_HIGH: begin adc_cs_n = 1'b0; adc_cmd = cmd_bit; busy = 1'b1; adc_sclk = 1'b1; end
            ST_DONE: begin busy = 1'b1; res_valid = 1'b1; end
        endcase
    end

    assign res_diff = cfg_q.diff;
    assign res_sel  = cfg_q.sel;

    // rising serial edges counted for the frame-length check
    logic [IDX_W:0] rise_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rise_cnt <= '0;
        else if (state == ST_IDLE && req_valid)
            rise_cnt <= '0;
        else if (state == ST_LOW && ph_last)
            rise_cnt <= rise_cnt + 1'b1;
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (adc_cs_n && !adc_sclk && !adc_cmd));

    // R2
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_cs_n) |-> (rise_cnt == (IDX_W+1)'(FRAME_BITS)));

    // R4
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(adc_cmd) |-> !adc_sclk);

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R6
    valid_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (adc_cs_n && busy));

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(res_diff) && $stable(res_sel)));
endmodule

// File: tb/mux_adc_ctrl_bench.sv
`timescale 1ns/1ps
module mux_adc_ctrl_bench;
    localparam int H     = 4;
    localparam int FRAME = 32 * H;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_diff = 1'b0, req_sel = 1'b0;
    logic       busy, res_valid, res_diff, res_sel, adc_cs_n, adc_sclk, adc_cmd;
    logic [7:0] res_data;
    wire        adc_dout;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    mux_adc_ctrl #(.HALF(H), .FRAME_BITS(16), .RES_W(8)) u_mux_adc_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_diff(req_diff),
        .req_sel(req_sel), .busy(busy), .res_valid(res_valid), .res_data(res_data),
        .res_diff(res_diff), .res_sel(res_sel), .adc_cs_n(adc_cs_n),
        .adc_sclk(adc_sclk), .adc_cmd(adc_cmd), .adc_dout(adc_dout)
    );

    logic [7:0] ch0 = 8'h00, ch1 = 8'h00;

    function automatic logic [7:0] conv(input logic d, input logic s,
                                        input logic [7:0] c0, input logic [7:0] c1);
        logic [7:0] p, n;
        if (!d) return s ? c1 : c0;
        p = s ? c1 : c0;
        n = s ? c0 : c1;
        return (p > n) ? p - n : 8'h00;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural converter model
    int         rises = 0;
    logic       m_diff = 1'b0, m_sel = 1'b0, dq = 1'b0;
    logic [7:0] m_val = 8'h00;
    assign adc_dout = adc_cs_n ? 1'bz : dq;

    always @(negedge adc_cs_n) begin
        rises = 0;
        dq    = 1'b0;
    end
    always @(posedge adc_sclk) if (!adc_cs_n) begin
        if (rises == 0) chk(adc_cmd === 1'b1, "R3", "start bit", adc_cmd, 1);
        if (rises == 1) m_diff = adc_cmd;
        if (rises == 2) begin
            m_sel = adc_cmd;
            m_val = conv(m_diff, m_sel, ch0, ch1);
        end
        rises++;
    end
    always @(negedge adc_sclk) if (!adc_cs_n) begin
        if (rises >= 8 && rises <= 15) dq = m_val[15 - rises];
        else                           dq = 1'b0;
    end

    // cycle reference model
    int         rt = -1;
    logic       e_diff = 1'b0, e_sel = 1'b0;
    logic [7:0] e_data = 8'h00;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) rt = -1;
        else if (rt < 0) begin
            if (req_valid) begin
                rt     = 0;
                e_diff = req_diff;
                e_sel  = req_sel;
                e_data = conv(req_diff, req_sel, ch0, ch1);
            end
        end else if (rt == FRAME) rt = -1;
        else rt++;
    end

    logic prev_sclk = 1'b0, prev_cmd = 1'b0;
    always @(negedge clk) if (rst_n && !finished) begin
        bit   in_f;
        logic x_sclk, x_cmd;
        int   b;
        in_f   = (rt >= 0) && (rt < FRAME);
        x_sclk = in_f && (((rt / H) % 2) == 1);
        b      = in_f ? rt / (2 * H) : -1;
        x_cmd  = (b == 0) ? 1'b1 : (b == 1) ? e_diff : (b == 2) ? e_sel : 1'b0;
        chk(adc_cs_n === !in_f, "R2", "adc_cs_n", adc_cs_n, !in_f);
        chk(adc_sclk === x_sclk, "R2", "adc_sclk", adc_sclk, x_sclk);
        chk(busy === (rt >= 0), "R7", "busy", busy, rt >= 0);
        chk(adc_cmd === x_cmd, "R3", "adc_cmd", adc_cmd, x_cmd);
        chk(res_valid === (rt == FRAME), "R6", "res_valid", res_valid, rt == FRAME);
        chk(res_diff === e_diff, "R6", "res_diff", res_diff, e_diff);
        chk(res_sel === e_sel, "R6", "res_sel", res_sel, e_sel);
        if (rt == FRAME)
            chk(res_data === e_data, "R5", "res_data", res_data, e_data);
        if (adc_sclk && prev_sclk)
            chk(adc_cmd === prev_cmd, "R4", "cmd stable in high", adc_cmd, prev_cmd);
        prev_sclk = adc_sclk;
        prev_cmd  = adc_cmd;
    end

    task automatic one_frame(input logic d, input logic s);
        @(negedge clk);
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_diff = d; req_sel = s;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (FRAME + 2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(adc_cs_n === 1'b1 && adc_sclk === 1'b0 && busy === 1'b0 && adc_cmd === 1'b0,
            "R1", "idle pins", {adc_cs_n, adc_sclk, busy, adc_cmd}, 4'b1000);
        chk(res_valid === 1'b0 && res_data === 8'h00, "R1", "reset result",
            res_data, 0);
        repeat (5) @(negedge clk);

        ch0 = 8'hA5; ch1 = 8'h3C;
        one_frame(1'b0, 1'b0);               // R5 single-ended channel 0
        one_frame(1'b0, 1'b1);               // R5 single-ended channel 1
        ch0 = 8'h90; ch1 = 8'h20;
        one_frame(1'b1, 1'b0);               // R3 differential, channel 0 positive
        one_frame(1'b1, 1'b1);               // R3 differential clipped to zero
        ch0 = 8'h01; ch1 = 8'hFF;
        one_frame(1'b1, 1'b1);
        ch0 = 8'hFF; ch1 = 8'h00;
        one_frame(1'b0, 1'b0);

        // R7 request during an open frame
        ch0 = 8'h5A; ch1 = 8'hC3;
        @(negedge clk);
        req_valid = 1'b1; req_diff = 1'b0; req_sel = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (40) @(negedge clk);
        req_valid = 1'b1; req_diff = 1'b1; req_sel = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(res_diff === 1'b0 && res_sel === 1'b1, "R7", "cfg during frame",
            {res_diff, res_sel}, 2'b01);

        // R8 request in the strobe cycle is ignored
        while (!res_valid) @(negedge clk);
        req_valid = 1'b1; req_diff = 1'b1; req_sel = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && adc_cs_n === 1'b1, "R8", "no frame after strobe req",
            busy, 0);
        repeat (4) @(negedge clk);

        // R8 held request starts back-to-back frames
        req_valid = 1'b1; req_diff = 1'b0; req_sel = 1'b0;
        repeat (2 * FRAME + 3) @(negedge clk);
        req_valid = 1'b0;
        repeat (FRAME + 4) @(negedge clk);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule